// File: doc/BRIEF.md
# Overlay-Mapped Dual-Access RAM

This block is the on-chip working memory of a 16-bit fixed-point signal-processing core. It serves three requesters in every clock: two data-space ports, A and B, which may read or write, and one program-space fetch port, P, which only reads. The storage is split into two independent banks, and address bit `BANK_AW` picks the bank. Each bank can serve two reads, or one read and one write, in the same clock.

Data addresses claim the RAM only inside a window. The window starts at `LO_ADDR` (0x0060), so the lowest data words fall through to other resources. It ends at the top of the two banks. With the default `BANK_AW = 10` each bank holds 1K words and the window is 0x0060–0x07FF. With `BANK_AW = 13` each bank holds 8K words and the window is 0x0060–0x3FFF.

An overlay control bit is registered from `ovl_in` on every clock and resets to 0. While it is set, program fetches inside the same window read the same RAM. While it is clear, those fetches miss. When more accesses target one bank than it can take, a conflict is flagged in the same cycle. Port A always wins. Port B wins next. The losing port sees a stall and repeats its request on the next cycle.

Top module: `ovl_dual_ram`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `a_hit`, `b_hit` and `p_hit` are 0 and all read data is 0. With no requests, `b_stall`, `p_stall` and `conflict` are 0.
- R2: A data request on A or B gives `*_hit` = 1 one cycle later only if its address is in 0x0060–0x07FF and it was not stalled. Addresses 0x005F and 0x0800 give a miss.
- R3: A read that hits returns the stored word one cycle after the request. A miss or a stalled request returns 0.
- R4: A data write (`*_we` = 1) that hits stores `*_wdata`. A write outside the window, or a stalled write, changes no word. A write to 0x0860 leaves 0x0060 unchanged.
- R5: A read of the word being written in the same cycle returns the old contents. This holds on a second port or on the program port.
- R6: Two reads to the same bank in one cycle are both served, with no stall and no conflict.
- R7: When A and B both write in-window words of the same bank in one cycle, `b_stall` and `conflict` are 1 in that cycle. A's write is stored and B's is not.
- R8: A program fetch hits, and returns the RAM word, only when the overlay register is 1 and `p_addr` is in 0x0060–0x07FF.
- R9: The overlay register resets to 0. It takes `ovl_in` at every clock edge, and decoding uses the value captured at the previous edge.
- R10: When A and B are both served in one bank and P is an in-window fetch to that bank, `p_stall` and `conflict` are 1 in that cycle and P gets no hit. A and B are still served.
- R11: Accesses that spread over both banks, with no more than two per bank, are all served with no conflict.
- R12: A program fetch at 0xFF80 never hits, whatever the overlay state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovl_in | input | 1 | Overlay enable, registered every clock |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 16 | Port A data address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data, one cycle later |
| a_hit | output | 1 | Port A was served by the RAM |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 16 | Port B data address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data, one cycle later |
| b_hit | output | 1 | Port B was served by the RAM |
| b_stall | output | 1 | Port B lost arbitration this cycle |
| p_req | input | 1 | Program fetch request |
| p_addr | input | 16 | Program fetch address |
| p_rdata | output | 16 | Program fetch data, one cycle later |
| p_hit | output | 1 | Program fetch was served by the RAM |
| p_stall | output | 1 | Program fetch lost arbitration this cycle |
| conflict | output | 1 | A bank was over-subscribed this cycle |

## Verification
The bench first fills the whole window. It then drives directed patterns:
- the window edges 0x005F, 0x0060, 0x07FF and 0x0800, which separate in-window decode from aliasing of upper address bits;
- a read and a write to one word, which exposes write-first against read-first ordering;
- two reads and two writes in one bank, which separate a legal pair from an over-subscribed one;
- three accesses to one bank against three spread over both banks, which tell a real conflict from a false one;
- overlay toggling, which shows the one-cycle registration of the control bit.

A long random phase follows. It draws addresses from a small set of hot words and boundary values so that collisions, same-word read/write pairs and overlay changes happen often. Every response is compared against a shadow array.

// File: rtl/ovl_ram_pkg.sv
package ovl_ram_pkg;

  // Which requester drives a bank slot this cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_P    = 2'd3
  } src_e;

endpackage

// File: rtl/ovl_addr_decode.sv
module ovl_addr_decode #(
  parameter int            AW      = 16,
  parameter int            BANK_AW = 10,
  parameter logic [AW-1:0] LO_ADDR = 16'h0060
) (
  input  logic [AW-1:0]      addr,
  output logic               in_win,
  output logic               bank,
  output logic [BANK_AW-1:0] idx
);

  // Window: at or above LO_ADDR and below the top of both banks
  assign in_win = (addr >= LO_ADDR) && (addr[AW-1:BANK_AW+1] == '0);
  assign bank   = addr[BANK_AW];
  assign idx    = addr[BANK_AW-1:0];

endmodule

// File: rtl/ovl_bank_arb.sv
module ovl_bank_arb
  import ovl_ram_pkg::*;
(
  input  logic wa,
  input  logic a_we,
  input  logic wb,
  input  logic b_we,
  input  logic wp,
  output logic gb,
  output logic gp,
  output logic conflict,
  output src_e sel0,
  output src_e sel1,
  output logic wr0
);

  // Slot 0 reads or writes and slot 1 only reads.
  // Port A always wins, then B, then P.
  assign gb       = wb && !(wa && a_we && b_we);
  assign gp       = wp && !(wa && gb);
  assign conflict = (wb && !gb) || (wp && !gp);

  always_comb begin
    sel0 = SRC_NONE;
    sel1 = gp ? SRC_P : SRC_NONE;
    if (wa && gb) begin
      sel0 = b_we ? SRC_B : SRC_A;
      sel1 = b_we ? SRC_A : SRC_B;
    end else if (wa) begin
      sel0 = SRC_A;
    end else if (gb) begin
      sel0 = SRC_B;
    end
  end

  assign wr0 = ((sel0 == SRC_A) && a_we) || ((sel0 == SRC_B) && b_we);

endmodule

// File: rtl/ovl_ram_bank.sv
module ovl_ram_bank #(
  parameter int DW      = 16,
  parameter int BANK_AW = 10
) (
  input  logic               clk,
  input  logic               we0,
  input  logic [BANK_AW-1:0] addr0,
  input  logic [DW-1:0]      wdata0,
  input  logic [BANK_AW-1:0] addr1,
  output logic [DW-1:0]      rdata0,
  output logic [DW-1:0]      rdata1
);

  localparam int DEPTH = 1 << BANK_AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first: both reads register the contents held before this edge's write
  always_ff @(posedge clk) begin
    rdata0 <= mem[addr0];
    rdata1 <= mem[addr1];
    if (we0) mem[addr0] <= wdata0;
  end

endmodule

// File: rtl/ovl_dual_ram.sv
module ovl_dual_ram
  import ovl_ram_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            AW      = 16,
  parameter int            BANK_AW = 10,
  parameter logic [AW-1:0] LO_ADDR = 16'h0060
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovl_in,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_hit,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_hit,
  output logic          b_stall,
  input  logic          p_req,
  input  logic [AW-1:0] p_addr,
  output logic [DW-1:0] p_rdata,
  output logic          p_hit,
  output logic          p_stall,
  output logic          conflict
);

  localparam int NB = 2;

  logic ovl_q;

  logic               a_in, b_in, p_in;
  logic               a_bk, b_bk, p_bk;
  logic [BANK_AW-1:0] a_idx, b_idx, p_idx;

  ovl_addr_decode #(.AW(AW), .BANK_AW(BANK_AW), .LO_ADDR(LO_ADDR)) u_dec_a (
    .addr(a_addr), .in_win(a_in), .bank(a_bk), .idx(a_idx));
  ovl_addr_decode #(.AW(AW), .BANK_AW(BANK_AW), .LO_ADDR(LO_ADDR)) u_dec_b (
    .addr(b_addr), .in_win(b_in), .bank(b_bk), .idx(b_idx));
  ovl_addr_decode #(.AW(AW), .BANK_AW(BANK_AW), .LO_ADDR(LO_ADDR)) u_dec_p (
    .addr(p_addr), .in_win(p_in), .bank(p_bk), .idx(p_idx));

  logic a_any, b_any, p_any;
  assign a_any = a_req && a_in;
  assign b_any = b_req && b_in;
  assign p_any = p_req && p_in && ovl_q;

  logic [NB-1:0] wa, wb, wp, gb, gp, cf, wr0;
  src_e          sel0 [NB];
  src_e          sel1 [NB];
  logic [DW-1:0] rd0  [NB];
  logic [DW-1:0] rd1  [NB];

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic [BANK_AW-1:0] ad0, ad1;
    logic [DW-1:0]      wd0;

    assign wa[k] = a_any && (a_bk == 1'(k));
    assign wb[k] = b_any && (b_bk == 1'(k));
    assign wp[k] = p_any && (p_bk == 1'(k));

    ovl_bank_arb u_arb (
      .wa(wa[k]), .a_we(a_we), .wb(wb[k]), .b_we(b_we), .wp(wp[k]),
      .gb(gb[k]), .gp(gp[k]), .conflict(cf[k]),
      .sel0(sel0[k]), .sel1(sel1[k]), .wr0(wr0[k]));

    always_comb begin
      ad0 = (sel0[k] == SRC_B) ? b_idx : a_idx;
      wd0 = (sel0[k] == SRC_B) ? b_wdata : a_wdata;
      case (sel1[k])
        SRC_A:   ad1 = a_idx;
        SRC_B:   ad1 = b_idx;
        default: ad1 = p_idx;
      endcase
    end

    ovl_ram_bank #(.DW(DW), .BANK_AW(BANK_AW)) u_mem (
      .clk(clk), .we0(wr0[k]), .addr0(ad0), .wdata0(wd0),
      .addr1(ad1), .rdata0(rd0[k]), .rdata1(rd1[k]));
  end

  assign b_stall  = b_any && !gb[b_bk];
  assign p_stall  = p_any && !gp[p_bk];
  assign conflict = |cf;

  // Which bank and slot each port's data comes back from
  logic a_bk_q, b_bk_q, p_bk_q;
  logic a_sl_q, b_sl_q, p_sl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_q  <= 1'b0;
      a_hit  <= 1'b0;
      b_hit  <= 1'b0;
      p_hit  <= 1'b0;
      a_bk_q <= 1'b0;
      b_bk_q <= 1'b0;
      p_bk_q <= 1'b0;
      a_sl_q <= 1'b0;
      b_sl_q <= 1'b0;
      p_sl_q <= 1'b0;
    end else begin
      ovl_q  <= ovl_in;
      a_hit  <= a_any;
      b_hit  <= b_any && !b_stall;
      p_hit  <= p_any && !p_stall;
      a_bk_q <= a_bk;
      b_bk_q <= b_bk;
      p_bk_q <= p_bk;
      a_sl_q <= (sel1[a_bk] == SRC_A);
      b_sl_q <= (sel1[b_bk] == SRC_B);
      p_sl_q <= (sel1[p_bk] == SRC_P);
    end
  end

  always_comb begin
    a_rdata = '0;
    b_rdata = '0;
    p_rdata = '0;
    if (a_hit) a_rdata = a_sl_q ? rd1[a_bk_q] : rd0[a_bk_q];
    if (b_hit) b_rdata = b_sl_q ? rd1[b_bk_q] : rd0[b_bk_q];
    if (p_hit) p_rdata = p_sl_q ? rd1[p_bk_q] : rd0[p_bk_q];
  end

  // ---------------- assertions ----------------
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!a_hit && !b_hit && !p_hit));

  p_low_miss_r2: assert property (@(posedge clk) disable iff (rst)
    (a_req && (a_addr < LO_ADDR)) |=> !a_hit);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!a_hit && !b_hit && !p_hit) |-> (a_rdata == '0 && b_rdata == '0 && p_rdata == '0));

  p_bstall_nohit_r7: assert property (@(posedge clk) disable iff (rst)
    b_stall |=> !b_hit);

  p_ovl_off_r8: assert property (@(posedge clk) disable iff (rst)
    (p_req && !ovl_q) |=> !p_hit);

  p_pstall_nohit_r10: assert property (@(posedge clk) disable iff (rst)
    p_stall |=> !p_hit);

  p_stall_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (b_stall || p_stall) |-> conflict);

  p_rom_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    (p_req && (p_addr == 16'hFF80)) |=> !p_hit);

endmodule

// File: tb/ovl_dual_ram_test.sv
module ovl_dual_ram_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ovl_in = 1'b0;
  logic        a_req = 1'b0, a_we = 1'b0;
  logic [15:0] a_addr = '0, a_wdata = '0;
  logic        b_req = 1'b0, b_we = 1'b0;
  logic [15:0] b_addr = '0, b_wdata = '0;
  logic        p_req = 1'b0;
  logic [15:0] p_addr = '0;
  logic [15:0] a_rdata, b_rdata, p_rdata;
  logic        a_hit, b_hit, p_hit, b_stall, p_stall, conflict;

  always #10 clk = ~clk;

  ovl_dual_ram uut (
    .clk(clk), .rst(rst), .ovl_in(ovl_in),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_hit(a_hit),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_hit(b_hit), .b_stall(b_stall),
    .p_req(p_req), .p_addr(p_addr), .p_rdata(p_rdata), .p_hit(p_hit),
    .p_stall(p_stall), .conflict(conflict));

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "init";
  logic  ovl_prev = 1'b0;
  logic [15:0] sh [0:2047];

  function automatic bit inwin(logic [15:0] ad);
    return (ad >= 16'h0060) && (ad < 16'h0800);
  endfunction

  function automatic bit bk(logic [15:0] ad);
    return ad[10];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s (%s) actual=%h expected=%h", req, what, cur_tag, act, exp);
    end
  endtask

  task automatic step(input logic ar, input logic aw, input logic [15:0] aa, input logic [15:0] ad,
                      input logic br, input logic bw, input logic [15:0] ba, input logic [15:0] bd,
                      input logic pr, input logic [15:0] pa, input logic ov);
    logic ovl_cur, wa, wb, wp, gb, gp, eb, ep;
    logic [15:0] ea, edb, edp;
    ovl_cur = ovl_prev;
    a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_addr = ba; b_wdata = bd;
    p_req = pr; p_addr = pa; ovl_in = ov;
    ovl_prev = ov;
    #1;
    wa = ar && inwin(aa);
    wb = br && inwin(ba);
    wp = pr && ovl_cur && inwin(pa);
    gb = wb && !(wa && aw && bw && (bk(aa) == bk(ba)));
    gp = wp && !(wa && gb && (bk(aa) == bk(pa)) && (bk(ba) == bk(pa)));
    eb = wb && !gb;
    ep = wp && !gp;
    chk("R7", "b_stall", b_stall, eb);
    chk("R10", "p_stall", p_stall, ep);
    chk("R10", "conflict", conflict, eb || ep);
    ea  = wa ? sh[aa[10:0]] : 16'h0;
    edb = gb ? sh[ba[10:0]] : 16'h0;
    edp = gp ? sh[pa[10:0]] : 16'h0;
    if (wa && aw) sh[aa[10:0]] = ad;
    if (gb && bw) sh[ba[10:0]] = bd;
    @(negedge clk);
    chk("R2", "a_hit", a_hit, wa);
    chk("R2", "b_hit", b_hit, gb);
    chk("R8", "p_hit", p_hit, gp);
    chk("R3", "a_rdata", a_rdata, ea);
    chk("R3", "b_rdata", b_rdata, edb);
    chk("R3", "p_rdata", p_rdata, edp);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ovl_prev);
  endtask

  function automatic logic [15:0] pick();
    int r;
    r = int'($urandom % 12);
    case (r)
      0: return 16'h005F;
      1: return 16'h0060;
      2: return 16'h0061;
      3: return 16'h03FF;
      4: return 16'h0400;
      5: return 16'h07FF;
      6: return 16'h0800;
      7: return 16'hFF80;
      8, 9: return 16'h0060 + 16'($urandom % 8);
      10: return 16'h0400 + 16'($urandom % 8);
      default: return 16'($urandom % 16'h1000);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7153));
    // Reset with overlay input high and a pending fetch
    rst = 1'b1; ovl_in = 1'b1; p_req = 1'b1; p_addr = 16'h0060;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R1";
    chk("R1", "a_hit", a_hit, 0);
    chk("R1", "b_hit", b_hit, 0);
    chk("R1", "p_hit", p_hit, 0);
    chk("R1", "a_rdata", a_rdata, 0);
    chk("R1", "p_rdata", p_rdata, 0);
    chk("R1", "p_stall", p_stall, 0);
    chk("R1", "conflict", conflict, 0);
    rst = 1'b0;
    ovl_prev = 1'b0;
    cur_tag = "R9";
    // First cycle after reset: overlay register still 0, so the fetch misses
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0060, 1'b0);

    cur_tag = "fill";
    for (int i = 0; i < 1024; i++) begin
      step(i >= 16'h60, 1, 16'(i), 16'(i * 16'h9E37 + 16'h1111),
           1, 1, 16'(i + 16'h400), 16'(i * 16'h3A5B + 16'h7777),
           0, 0, 1'b0);
    end

    cur_tag = "R2";
    step(1, 0, 16'h005F, 0, 1, 0, 16'h0060, 0, 0, 0, 1'b0);
    step(1, 0, 16'h07FF, 0, 1, 0, 16'h0800, 0, 0, 0, 1'b0);
    idle();

    cur_tag = "R4";
    step(1, 1, 16'h0060, 16'h1234, 1, 1, 16'h0860, 16'hDEAD, 0, 0, 1'b0);
    step(1, 1, 16'h005F, 16'hFFFF, 1, 0, 16'h0060, 0, 0, 0, 1'b0);
    step(1, 0, 16'h0060, 0, 0, 0, 0, 0, 0, 0, 1'b0);

    cur_tag = "R5";
    step(1, 1, 16'h0100, 16'h5555, 1, 0, 16'h0100, 0, 0, 0, 1'b0);
    step(0, 0, 0, 0, 1, 0, 16'h0100, 0, 0, 0, 1'b0);

    cur_tag = "R6";
    step(1, 0, 16'h0060, 0, 1, 0, 16'h0061, 0, 0, 0, 1'b0);
    step(1, 0, 16'h0400, 0, 1, 0, 16'h07FF, 0, 0, 0, 1'b0);

    cur_tag = "R7";
    step(1, 1, 16'h0200, 16'h0001, 1, 1, 16'h0201, 16'h0002, 0, 0, 1'b0);
    step(1, 0, 16'h0200, 0, 1, 0, 16'h0201, 0, 0, 0, 1'b0);

    cur_tag = "R9";
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0060, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0060, 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0060, 1'b1);

    cur_tag = "R10";
    step(1, 0, 16'h0060, 0, 1, 0, 16'h0061, 0, 1, 16'h0062, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0062, 1'b1);
    step(1, 1, 16'h0063, 16'hAAAA, 1, 0, 16'h0063, 0, 1, 16'h0063, 1'b1);
    step(1, 0, 16'h0063, 0, 0, 0, 0, 0, 1, 16'h0063, 1'b1);

    cur_tag = "R11";
    step(1, 0, 16'h0060, 0, 1, 0, 16'h0061, 0, 1, 16'h0400, 1'b1);
    step(1, 1, 16'h0401, 16'h4321, 1, 0, 16'h0070, 0, 1, 16'h0401, 1'b1);

    cur_tag = "R12";
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFF80, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFF80, 1'b0);

    cur_tag = "R8";
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h07FF, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0800, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h005F, 1'b0);
    idle();

    cur_tag = "random";
    for (int n = 0; n < 3000; n++) begin
      logic ov;
      ov = (($urandom % 8) == 0) ? ~ovl_prev : ovl_prev;
      step(1'($urandom), 1'($urandom), pick(), 16'($urandom),
           1'($urandom), 1'($urandom), pick(), 16'($urandom),
           1'($urandom), pick(), ov);
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule